// File: doc/BRIEF.md
# Segmented capture address generator

This block produces the write address for a waveform capture memory shared by 1, 2, 4, 8 or 16 interleaved channels. The memory is split into equal segments, one for each channel. The channel index from the conversion sequencer forms the upper address bits. A sample index common to all channels forms the lower bits, and it advances once per completed scan. The lower half of every segment is a circular pre-trigger buffer and the upper half holds post-trigger data.

On a trigger the sample index jumps to the first upper-half location. In the same cycle the next address to be written goes out on a time-stamp write port, at the slot given by an event counter. An end-of-event strobe puts the index back where pre-trigger recording left off and advances the event counter. In continuous mode the whole segment is one ring. A wrap counter above the memory address bits counts how many times the memory has wrapped, and the full flag does not halt recording. A host reads the pointer through a latch that refreshes only at scan ends and when a read finishes, so the first read after an idle change returns the older value.

Top module: `seg_capture_addr`

## Requirements
- R1: `wr_addr_o` equals the sample index OR'ed with `(chan_i & (N-1)) << (MEM_AW - log2 N)`. N is taken from `ch_cnt_i` when it holds 1, 2, 4, 8 or 16; any other code selects 16 channels.
- R2: A scan completes on a write (`wr_en_o`=1) with `chan_i` equal to N-1. In the pre-trigger phase without continuous mode, each completed scan advances the index by one, modulo half a segment, so the index stays in the lower half.
- R3: A trigger in the pre-trigger phase, outside continuous mode, sets the index to half a segment, enters the post-trigger phase and sets `half_o`. A write in the trigger cycle still uses the old address.
- R4: In the post-trigger phase each completed scan advances the index. A completed scan at the top location of the segment sets `full_o` and the index holds there. While `full_o`=1 and continuous mode is off, `wr_en_o` stays 0.
- R5: End of event in the post-trigger phase restores the index saved at the trigger, returns to the pre-trigger phase and advances the event counter by one, modulo 2^TS_AW.
- R6: An accepted trigger pulses `ts_we_o` for that cycle, with `ts_addr_o` equal to the event counter and `ts_data_o` equal to the index before the jump.
- R7: In continuous mode the index runs over the whole segment. Passing from the top location to 0 increments the wrap count and sets `full_o`. Reaching half a segment sets `half_o`. Writes continue after `full_o` is set, and triggers are ignored.
- R8: `clr_ptr_i` clears the sample index and the wrap count. It takes precedence over triggers, end of event and scan advance in that cycle.
- R9: `rd_data_o` is {wrap count, MEM_AW-bit index with the segment bits zero}. It loads the next pointer value at a completed scan, and in the cycle after a read strobe ends.
- R10: While `rd_i`=1 the latch does not load, so `rd_data_o` is stable in the following cycle.
- R11: `clr_flags_i[0]` clears `full_o` and `clr_flags_i[1]` clears `half_o`. A flag set in the same cycle wins.
- R12: After reset the index, wrap count, flags, event counter and latch are all zero, and the phase is pre-trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One conversion is ready to be stored |
| chan_i | input | MAX_CH_LOG | Channel of the current conversion |
| trig_i | input | 1 | Trigger strobe |
| eoe_i | input | 1 | End-of-event strobe |
| cont_i | input | 1 | Continuous mode |
| ch_cnt_i | input | MAX_CH_LOG+1 | Number of channels |
| clr_ptr_i | input | 1 | Clear pointer and wrap count |
| clr_flags_i | input | 2 | Clear full (bit 0), half (bit 1) |
| rd_i | input | 1 | Host pointer read strobe |
| wr_en_o | output | 1 | Store this conversion |
| wr_addr_o | output | MEM_AW | Write address |
| half_o | output | 1 | Half-full flag |
| full_o | output | 1 | Full flag |
| ts_we_o | output | 1 | Time-stamp write |
| ts_addr_o | output | TS_AW | Time-stamp slot (event counter) |
| ts_data_o | output | MEM_AW | Address stored at the trigger |
| rd_data_o | output | MEM_AW+WRAP_W | Latched pointer readback |

## Verification
The bench goes after the pre-trigger ring at the half-segment edge. If that wrap is wrong, the index spills into post-trigger space and overwrites captured data. It fills the post half to the top: a block that fails to hold there either rolls over into another channel's segment or keeps writing after full. It reads the pointer straight after end of event and after a clear. A latch without the two-read behaviour returns the new value at once, and one that loads during a read changes under the host. It also checks the continuous wrap count, event counter wrap in the time-stamp slot, and the unlisted channel code. Errors there show up as a stalled wrap count, a time stamp written to the wrong slot, or overlapping channel segments.

// File: rtl/sca_pkg.sv
package sca_pkg;
   typedef enum logic {PH_PRE = 1'b0, PH_POST = 1'b1} phase_e;
endpackage

// File: rtl/sca_chdec.sv
// Channel count decode: log2 of channel count and channel mask; unlisted codes fall back to the maximum.
module sca_chdec #(
   parameter int MAX_CH_LOG = 4
) (
   input  logic [MAX_CH_LOG:0]                  ch_cnt_i,
   output logic [$clog2(MAX_CH_LOG+1)-1:0]      k_o,
   output logic [MAX_CH_LOG-1:0]                mask_o
);
   localparam int CW = MAX_CH_LOG + 1;
   localparam int KW = $clog2(MAX_CH_LOG + 1);

   always_comb begin
      k_o = KW'(MAX_CH_LOG);
      for (int i = 0; i < MAX_CH_LOG; i++) begin
         if (ch_cnt_i == (CW'(1) << i)) k_o = KW'(i);
      end
      mask_o = MAX_CH_LOG'((1 << k_o) - 1);
   end
endmodule

// File: rtl/sca_ptr.sv
// Sample index, phase, wrap count and fill flags.
module sca_ptr
   import sca_pkg::*;
#(
   parameter int MEM_AW     = 17,
   parameter int WRAP_W     = 7,
   parameter int MAX_CH_LOG = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [$clog2(MAX_CH_LOG+1)-1:0]   k_i,
   input  logic                              cont_i,
   input  logic                              done_i,
   input  logic                              trig_i,
   input  logic                              eoe_i,
   input  logic                              clr_ptr_i,
   input  logic [1:0]                        clr_flags_i,
   output logic [MEM_AW-1:0]                 idx_o,
   output logic [MEM_AW-1:0]                 idx_d_o,
   output logic [WRAP_W-1:0]                 wrap_d_o,
   output logic                              half_o,
   output logic                              full_o,
   output logic                              trig_ok_o,
   output logic                              eoe_ok_o
);
   logic [MEM_AW-1:0] idx_q, idx_d, save_q, save_d;
   logic [MEM_AW-1:0] seg_top, half_m, pre_m;
   logic [WRAP_W-1:0] wrap_q, wrap_d;
   phase_e            ph_q, ph_d;
   logic              half_q, full_q, set_h, set_f;
   logic              trig_ok, eoe_ok, ring_all;

   assign seg_top = {MEM_AW{1'b1}} >> k_i;
   assign pre_m   = seg_top >> 1;
   assign half_m  = pre_m + MEM_AW'(1);

   assign trig_ok  = trig_i && !cont_i && (ph_q == PH_PRE) && !clr_ptr_i;
   assign eoe_ok   = eoe_i && (ph_q == PH_POST) && !clr_ptr_i;
   assign ring_all = cont_i || (ph_q == PH_POST);

   always_comb begin
      idx_d  = idx_q;
      wrap_d = wrap_q;
      ph_d   = ph_q;
      save_d = save_q;
      set_h  = 1'b0;
      set_f  = 1'b0;
      if (clr_ptr_i) begin
         idx_d  = '0;
         wrap_d = '0;
      end else if (trig_ok) begin
         save_d = idx_q;
         idx_d  = half_m;
         ph_d   = PH_POST;
         set_h  = 1'b1;
      end else if (eoe_ok) begin
         idx_d = save_q;
         ph_d  = PH_PRE;
      end else if (done_i) begin
         if (ring_all && idx_q == seg_top) begin
            set_f = 1'b1;
            if (cont_i) begin
               idx_d  = '0;
               wrap_d = wrap_q + WRAP_W'(1);
            end
         end else if (ring_all) begin
            idx_d = idx_q + MEM_AW'(1);
            if (idx_d == half_m) set_h = 1'b1;
         end else begin
            idx_d = (idx_q + MEM_AW'(1)) & pre_m;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         save_q <= '0;
         wrap_q <= '0;
         ph_q   <= PH_PRE;
         half_q <= 1'b0;
         full_q <= 1'b0;
      end else begin
         idx_q  <= idx_d;
         save_q <= save_d;
         wrap_q <= wrap_d;
         ph_q   <= ph_d;
         half_q <= set_h | (half_q & ~clr_flags_i[1]);
         full_q <= set_f | (full_q & ~clr_flags_i[0]);
      end
   end

   assign idx_o     = idx_q;
   assign idx_d_o   = idx_d;
   assign wrap_d_o  = wrap_d;
   assign half_o    = half_q;
   assign full_o    = full_q;
   assign trig_ok_o = trig_ok;
   assign eoe_ok_o  = eoe_ok;

   assert_seg_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q & ~seg_top) == '0);
   assert_pre_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PRE && !cont_i) |-> (idx_q & half_m) == '0);
   assert_trig_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_ok |=> (idx_q == $past(half_m)) && (ph_q == PH_POST) && half_q);
   assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !cont_i && !clr_ptr_i && !trig_ok && !eoe_ok) |=> idx_q == $past(idx_q));
   assert_eoe_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eoe_ok |=> (idx_q == $past(save_q)) && (ph_q == PH_PRE));
   assert_cont_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_i && done_i && !clr_ptr_i && idx_q == seg_top) |=>
         (wrap_q == $past(wrap_q) + WRAP_W'(1)) && full_q && idx_q == '0);
endmodule

// File: rtl/sca_tslog.sv
// Event counter and time-stamp write port.
module sca_tslog #(
   parameter int MEM_AW = 17,
   parameter int TS_AW  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_ok_i,
   input  logic              eoe_ok_i,
   input  logic [MEM_AW-1:0] idx_i,
   output logic              ts_we_o,
   output logic [TS_AW-1:0]  ts_addr_o,
   output logic [MEM_AW-1:0] ts_data_o
);
   logic [TS_AW-1:0] evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        evt_q <= '0;
      else if (eoe_ok_i) evt_q <= evt_q + TS_AW'(1);
   end

   assign ts_we_o   = trig_ok_i;
   assign ts_addr_o = evt_q;
   assign ts_data_o = idx_i;

   assert_evt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eoe_ok_i |=> evt_q == $past(evt_q) + TS_AW'(1));
   assert_evt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !eoe_ok_i |=> $stable(evt_q));
endmodule

// File: rtl/sca_rdlatch.sv
// Host readback latch: loads at scan end or when a read finishes, never while a read is active.
module sca_rdlatch #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_i,
   input  logic          done_i,
   input  logic [DW-1:0] live_i,
   output logic [DW-1:0] rd_data_o
);
   logic          rd_prev;
   logic [DW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b0;
         lat_q   <= '0;
      end else begin
         rd_prev <= rd_i;
         if (!rd_i && (done_i || rd_prev)) lat_q <= live_i;
      end
   end

   assign rd_data_o = lat_q;

   assert_read_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> $stable(rd_data_o));
endmodule

// File: rtl/seg_capture_addr.sv
module seg_capture_addr
   import sca_pkg::*;
#(
   parameter int MEM_AW     = 17,
   parameter int WRAP_W     = 7,
   parameter int TS_AW      = 13,
   parameter int MAX_CH_LOG = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step_i,
   input  logic [MAX_CH_LOG-1:0]     chan_i,
   input  logic                      trig_i,
   input  logic                      eoe_i,
   input  logic                      cont_i,
   input  logic [MAX_CH_LOG:0]       ch_cnt_i,
   input  logic                      clr_ptr_i,
   input  logic [1:0]                clr_flags_i,
   input  logic                      rd_i,
   output logic                      wr_en_o,
   output logic [MEM_AW-1:0]         wr_addr_o,
   output logic                      half_o,
   output logic                      full_o,
   output logic                      ts_we_o,
   output logic [TS_AW-1:0]          ts_addr_o,
   output logic [MEM_AW-1:0]         ts_data_o,
   output logic [MEM_AW+WRAP_W-1:0]  rd_data_o
);
   localparam int KW = $clog2(MAX_CH_LOG + 1);
   localparam int DW = MEM_AW + WRAP_W;

   if (MEM_AW < MAX_CH_LOG + 2) begin : g_bad_aw
      $error("MEM_AW too small for the channel split");
   end
   if (WRAP_W < 1 || TS_AW < 1 || MAX_CH_LOG < 1) begin : g_bad_w
      $error("WRAP_W, TS_AW and MAX_CH_LOG must be positive");
   end

   logic [KW-1:0]         k;
   logic [MAX_CH_LOG-1:0] mask;
   logic [MEM_AW-1:0]     idx, idx_d, chan_ext;
   logic [WRAP_W-1:0]     wrap_d;
   logic                  done, trig_ok, eoe_ok;

   sca_chdec #(.MAX_CH_LOG(MAX_CH_LOG)) u_dec (
      .ch_cnt_i (ch_cnt_i),
      .k_o      (k),
      .mask_o   (mask)
   );

   assign wr_en_o   = step_i && !(full_o && !cont_i);
   assign done      = wr_en_o && ((chan_i & mask) == mask);
   assign chan_ext  = MEM_AW'(chan_i & mask);
   assign wr_addr_o = idx | (chan_ext << (MEM_AW - int'(k)));

   sca_ptr #(.MEM_AW(MEM_AW), .WRAP_W(WRAP_W), .MAX_CH_LOG(MAX_CH_LOG)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .k_i         (k),
      .cont_i      (cont_i),
      .done_i      (done),
      .trig_i      (trig_i),
      .eoe_i       (eoe_i),
      .clr_ptr_i   (clr_ptr_i),
      .clr_flags_i (clr_flags_i),
      .idx_o       (idx),
      .idx_d_o     (idx_d),
      .wrap_d_o    (wrap_d),
      .half_o      (half_o),
      .full_o      (full_o),
      .trig_ok_o   (trig_ok),
      .eoe_ok_o    (eoe_ok)
   );

   sca_tslog #(.MEM_AW(MEM_AW), .TS_AW(TS_AW)) u_ts (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_ok_i (trig_ok),
      .eoe_ok_i  (eoe_ok),
      .idx_i     (idx),
      .ts_we_o   (ts_we_o),
      .ts_addr_o (ts_addr_o),
      .ts_data_o (ts_data_o)
   );

   sca_rdlatch #(.DW(DW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (rd_i),
      .done_i    (done),
      .live_i    ({wrap_d, idx_d}),
      .rd_data_o (rd_data_o)
   );

   assert_ts_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ts_we_o |-> (ts_data_o & ~(({MEM_AW{1'b1}} >> k) >> 1)) == '0);
endmodule

// File: tb/seg_capture_addr_tb.sv
module seg_capture_addr_tb;
   localparam int AW = 9;
   localparam int WW = 7;
   localparam int TW = 3;
   localparam int CL = 4;
   localparam int DW = AW + WW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          step = 0, trig = 0, eoe = 0, cont = 0, clr_ptr = 0, rd = 0;
   logic [CL-1:0] chan = '0;
   logic [CL:0]   ch_cnt = 5'd1;
   logic [1:0]    clr_flags = '0;
   logic          wr_en_o, half_o, full_o, ts_we_o;
   logic [AW-1:0] wr_addr_o, ts_data_o;
   logic [TW-1:0] ts_addr_o;
   logic [DW-1:0] rd_data_o;

   seg_capture_addr #(.MEM_AW(AW), .WRAP_W(WW), .TS_AW(TW), .MAX_CH_LOG(CL)) u_dut (
      .clk(clk), .rst_n(rst_n), .step_i(step), .chan_i(chan), .trig_i(trig), .eoe_i(eoe),
      .cont_i(cont), .ch_cnt_i(ch_cnt), .clr_ptr_i(clr_ptr), .clr_flags_i(clr_flags), .rd_i(rd),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .half_o(half_o), .full_o(full_o),
      .ts_we_o(ts_we_o), .ts_addr_o(ts_addr_o), .ts_data_o(ts_data_o), .rd_data_o(rd_data_o)
   );

   int n_cmp = 0, n_bad = 0;
   logic [AW-1:0] m_idx = '0, m_save = '0;
   logic [WW-1:0] m_wrap = '0;
   logic [TW-1:0] m_evt = '0;
   logic [DW-1:0] m_rdq = '0;
   logic m_post = 0, m_half = 0, m_full = 0, m_rdprev = 0;
   logic [DW-1:0] last_rd;
   logic [AW-1:0] last_addr, last_tsd;
   logic [TW-1:0] last_tsa;
   logic          last_tswe;

   function automatic int kfun(logic [CL:0] c);
      for (int i = 0; i < CL; i++) if (c == (CL+1)'(1 << i)) return i;
      return CL;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      int k, mask;
      logic [AW-1:0] top, hm, pm, nidx, eaddr;
      logic [WW-1:0] nw;
      logic wen, done, tok, eok, sf, sh;
      #1;
      k = kfun(ch_cnt);
      mask = (1 << k) - 1;
      top = AW'((1 << (AW - k)) - 1);
      pm = top >> 1;
      hm = pm + 1;
      wen = step && !(m_full && !cont);
      done = wen && ((int'(chan) & mask) == mask);
      tok = trig && !cont && !m_post && !clr_ptr;
      eok = eoe && m_post && !clr_ptr;
      eaddr = m_idx | AW'((int'(chan) & mask) << (AW - k));
      chk("R1 wr_addr", 32'(wr_addr_o), 32'(eaddr));
      chk("R4 wr_en", 32'(wr_en_o), 32'(wen));
      chk("R11 half", 32'(half_o), 32'(m_half));
      chk("R11 full", 32'(full_o), 32'(m_full));
      chk("R6 ts_we", 32'(ts_we_o), 32'(tok));
      if (tok) begin
         chk("R6 ts_addr", 32'(ts_addr_o), 32'(m_evt));
         chk("R6 ts_data", 32'(ts_data_o), 32'(m_idx));
      end
      chk("R9 rd_data", 32'(rd_data_o), 32'(m_rdq));
      last_rd = rd_data_o; last_addr = wr_addr_o;
      last_tswe = ts_we_o; last_tsa = ts_addr_o; last_tsd = ts_data_o;
      @(posedge clk);
      nidx = m_idx; nw = m_wrap; sf = 0; sh = 0;
      if (clr_ptr) begin
         nidx = '0; nw = '0;
      end else if (tok) begin
         m_save = m_idx; nidx = hm; m_post = 1; sh = 1;
      end else if (eok) begin
         nidx = m_save; m_post = 0; m_evt = m_evt + 1'b1;
      end else if (done) begin
         if ((cont || m_post) && m_idx == top) begin
            sf = 1;
            if (cont) begin nidx = '0; nw = m_wrap + 1'b1; end
         end else if (cont || m_post) begin
            nidx = m_idx + 1'b1;
            if (nidx == hm) sh = 1;
         end else begin
            nidx = (m_idx + 1'b1) & pm;
         end
      end
      m_half = sh | (m_half & ~clr_flags[1]);
      m_full = sf | (m_full & ~clr_flags[0]);
      if (!rd && (done || m_rdprev)) m_rdq = {nw, nidx};
      m_rdprev = rd;
      m_idx = nidx; m_wrap = nw;
      @(negedge clk);
      step = 0; trig = 0; eoe = 0; clr_ptr = 0; clr_flags = '0; rd = 0;
   endtask

   task automatic scans(int n);
      int nc;
      nc = 1 << kfun(ch_cnt);
      for (int s = 0; s < n; s++)
         for (int c = 0; c < nc; c++) begin
            step = 1; chan = CL'(c); tick();
         end
   endtask

   task automatic read_val(output logic [DW-1:0] v);
      rd = 1; tick(); v = last_rd;
      tick();
   endtask

   task automatic cfg(logic [CL:0] code, logic c);
      if (m_post) begin eoe = 1; tick(); end
      clr_ptr = 1; tick();
      ch_cnt = code; cont = c; tick();
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] v, v2;
      int cc;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 rd_data reset", 32'(rd_data_o), 0);
      chk("R12 half reset", 32'(half_o), 0);
      chk("R12 full reset", 32'(full_o), 0);
      chk("R12 ts_we reset", 32'(ts_we_o), 0);
      rst_n = 1;
      tick();
      // R1/R2: four channels, a few scans
      cfg(5'd4, 0);
      scans(3);
      // R2: pre-trigger ring of 16 with 16 channels, 20 scans -> index 4
      cfg(5'd16, 0);
      scans(20);
      read_val(v);
      chk("R2 pre ring wrap", 32'(v), 4);
      // R3/R6: trigger logs the old index
      trig = 1; tick();
      chk("R6 ts_data at trigger", 32'(last_tsd), 4);
      chk("R3 half after trigger", 32'(half_o), 1);
      // R4: fill post half to the top and hold
      scans(17);
      chk("R4 full at top", 32'(full_o), 1);
      step = 1; chan = 4'd15; tick();
      chk("R4 no write when full", 32'(wr_en_o), 0);
      // R5/R9: end of event then read twice
      eoe = 1; tick();
      read_val(v);
      read_val(v2);
      chk("R9 first read stale", 32'(v), 31);
      chk("R5 second read restored", 32'(v2), 4);
      // R11: flag clears
      clr_flags = 2'b11; tick();
      chk("R11 full cleared", 32'(full_o), 0);
      chk("R11 half cleared", 32'(half_o), 0);
      // R1: unlisted code 3 acts as 16 channels
      cfg(5'd3, 0);
      step = 1; chan = 4'd15; tick();
      chk("R1 code 3 as 16", 32'(last_addr), 15 << 5);
      // R7: continuous, one channel, 515 scans
      cfg(5'd1, 1);
      scans(515);
      chk("R7 full in cont", 32'(full_o), 1);
      chk("R7 half in cont", 32'(half_o), 1);
      trig = 1; tick();
      chk("R7 trigger ignored", 32'(last_tswe), 0);
      read_val(v);
      chk("R7 wrap count", 32'(v), (1 << AW) | 3);
      // R5: event counter wraps at 2^TS_AW
      cfg(5'd2, 0);
      clr_flags = 2'b11; tick();
      for (int i = 0; i < 8; i++) begin
         trig = 1; tick();
         chk("R5 ts slot", 32'(last_tsa), (1 + i) % 8);
         scans(2);
         eoe = 1; tick();
      end
      // R8: clear command
      scans(5);
      clr_ptr = 1; tick();
      read_val(v);
      read_val(v2);
      chk("R8 pointer cleared", 32'(v2), 0);
      // R10: long read while scans complete
      cfg(5'd1, 0);
      rd = 1; step = 1; chan = '0; tick();
      v = last_rd;
      rd = 1; step = 1; tick();
      rd = 1; step = 1; tick();
      chk("R10 stable during read", 32'(last_rd), 32'(v));
      tick();
      // random phase
      cc = 0;
      for (int it = 0; it < 6000; it++) begin
         int r, nc;
         if (it % 600 == 0) begin
            int pick;
            pick = $urandom % 6;
            cfg((pick == 5) ? 5'd6 : 5'(1 << pick), 1'($urandom % 3 == 0));
            cc = 0;
         end
         nc = 1 << kfun(ch_cnt);
         r = $urandom % 100;
         if (r < 72) begin
            step = 1; chan = CL'(cc); cc = (cc + 1) % nc;
         end else if (r < 76) trig = 1;
         else if (r < 80) eoe = 1;
         else if (r < 88) rd = 1;
         else if (r < 92) clr_flags = 2'($urandom);
         else if (r < 93) begin clr_ptr = 1; end
         tick();
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule